// File: doc/BRIEF.md
# SAR Converter Serial Output Port

This block is the device-side serial port of a 16-bit successive-approximation converter, built in synchronous logic. A fast system clock samples two host-driven pins: an active-low select and a serial shift clock. When the select falls, the port raises a one-cycle conversion request toward the conversion engine and begins a frame. The serial output is modelled as a data bit plus an output enable; the enable low stands for a released, high-impedance pin.

A frame has three parts. For four shift-clock falling edges the output stays released while the engine converts. On the fifth falling edge the port enables the pin, drives a low start bit and captures the engine's parallel result. Each later falling edge presents one result bit, most significant first, for sixteen bits. The falling edge after the last bit drives the pin low and raises a one-cycle completion pulse. The pin then stays low for any extra clocks until the select rises. Data changes only in response to falling edges, so the host can capture on either edge. A frame therefore needs at least 22 shift clocks, and 24 is a common choice. Raising the select at any point ends the frame and releases the pin.

The state machine has five states. ST_IDLE waits with the pin released. ST_LEAD counts the lead-in falling edges. ST_START holds the start bit. ST_DATA shifts out result bits. ST_TAIL holds the trailing low. Select falling takes ST_IDLE to ST_LEAD. The fifth falling edge takes ST_LEAD to ST_START. The next falling edge takes ST_START to ST_DATA. The falling edge after the sixteenth bit takes ST_DATA to ST_TAIL. Select high takes any state to ST_IDLE.

Top module: `sar_port_top`

## Requirements
- R1: After reset, dout_oe, dout, frame_done and conv_start are all 0.
- R2: Three system clocks after csn_in is seen high, dout_oe is 0, and it stays 0 for as long as csn_in stays high.
- R3: Each csn_in falling edge produces exactly one conv_start pulse of one cycle, and dout_oe is 0 while it is high.
- R4: dout_oe stays 0 through the first four sclk_in falling edges after csn_in falls. On the fifth, dout_oe rises with dout = 0.
- R5: On falling edges 6 to 21, dout carries result bits 15 down to 0 in that order. The result is the value on result_in at falling edge 5.
- R6: From falling edge 22 on, dout is 0 and dout_oe stays 1 until csn_in rises, however many clocks the frame has.
- R7: frame_done is a one-cycle pulse, raised once per frame on falling edge 22, with dout_oe = 1 and dout = 0.
- R8: While csn_in is low, dout changes only in the cycle that follows a detected sclk_in falling edge.
- R9: A csn_in rise partway through a frame aborts it with no frame_done. The next frame counts its falling edges from zero again.
- R10: When csn_in rises together with falling edge 22, the abort wins: dout_oe drops and frame_done is not raised.
- R11: Changes on result_in after falling edge 5 do not alter the bits of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk_in |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Host serial shift clock, asynchronous |
| csn_in | input | 1 | Host select, active low, asynchronous |
| result_in | input | 16 | Parallel conversion result from the engine |
| conv_start | output | 1 | One-cycle conversion request on select fall |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the serial pin (0 = released) |
| frame_done | output | 1 | One-cycle pulse when the trailing low is driven |

## Verification
The two events that can land in the same system cycle are the falling edge that completes the frame and a select rise that aborts it. The bench provokes this by moving sclk_in low and csn_in high in the same time step at falling edge 22. Both pins pass through identical synchronizer chains, so the two edges reach the state machine together. The bench expects the pin released three clocks later and the completion-pulse count unchanged. It then runs a full frame to confirm that the edge counter started from zero again.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_TAIL
    } port_state_t;

endpackage

// File: rtl/sar_port_sync.sv
module sar_port_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] level
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], pins[b]};
            end
        end

        assign level[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sar_port_shifter.sv
module sar_port_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word,
    output logic         msb
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/sar_port_top.sv
module sar_port_top
    import sar_port_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LEAD_FALLS  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              csn_in,
    input  logic [DATA_W-1:0] result_in,
    output logic              conv_start,
    output logic              dout,
    output logic              dout_oe,
    output logic              frame_done
);

    localparam int CNT_MAX = (DATA_W > LEAD_FALLS) ? DATA_W : LEAD_FALLS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_FALLS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    // pin synchronizers: bit 0 select (idles high), bit 1 shift clock
    logic [1:0] pin_lvl;
    logic       cs_s, sclk_s, cs_q, sclk_q;
    logic       cs_fell, sclk_fell;

    sar_port_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({sclk_in, csn_in}),
        .level(pin_lvl)
    );

    assign cs_s      = pin_lvl[0];
    assign sclk_s    = pin_lvl[1];
    assign cs_fell   = cs_q & ~cs_s;
    assign sclk_fell = sclk_q & ~sclk_s;

    port_state_t      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             load_word, shift_en, sh_msb;

    // next-state decision
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (cs_s) begin
            state_nxt = ST_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fell) begin
                        state_nxt = ST_LEAD;
                        cnt_nxt   = '0;
                    end
                end
                ST_LEAD: begin
                    if (sclk_fell) begin
                        if (cnt == LEAD_LAST) begin
                            state_nxt = ST_START;
                            cnt_nxt   = '0;
                        end else begin
                            cnt_nxt = cnt + CNT_ONE;
                        end
                    end
                end
                ST_START: begin
                    if (sclk_fell) begin
                        state_nxt = ST_DATA;
                        cnt_nxt   = CNT_ONE;
                    end
                end
                ST_DATA: begin
                    if (sclk_fell) begin
                        if (cnt == DATA_LAST) begin
                            state_nxt = ST_TAIL;
                        end else begin
                            cnt_nxt = cnt + CNT_ONE;
                        end
                    end
                end
                ST_TAIL: begin
                    state_nxt = ST_TAIL;
                end
                default: begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    assign load_word = (state == ST_LEAD) && (state_nxt == ST_START);
    assign shift_en  = sclk_fell && !cs_s &&
                       ((state == ST_START) || (state == ST_DATA));

    sar_port_shifter #(
        .W(DATA_W)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_word),
        .shift(shift_en),
        .word (result_in),
        .msb  (sh_msb)
    );

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            cnt    <= cnt_nxt;
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= 1'b0;
            dout_oe    <= 1'b0;
            frame_done <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            dout_oe    <= (state_nxt == ST_START) || (state_nxt == ST_DATA) ||
                          (state_nxt == ST_TAIL);
            frame_done <= (state == ST_DATA) && (state_nxt == ST_TAIL);
            conv_start <= (state == ST_IDLE) && (state_nxt == ST_LEAD);
            if (state_nxt != ST_DATA) begin
                dout <= 1'b0;
            end else if (shift_en) begin
                dout <= sh_msb;
            end
        end
    end

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dout_oe); // R2
    AST_CONV_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !dout_oe); // R3
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7
    AST_DONE_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (dout_oe && !dout)); // R7
    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fell && !cs_s) |=> $stable(dout)); // R8

endmodule

// File: tb/test_sar_port_top.sv
module test_sar_port_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int HALF       = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_in = 1'b0;
    logic         csn_in = 1'b1;
    logic [W-1:0] result_in = '0;
    logic         conv_start, dout, dout_oe, frame_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int conv_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        logic oe;
        logic d;
        int   idx;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_port_top i_sar_port_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .csn_in    (csn_in),
        .result_in (result_in),
        .conv_start(conv_start),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .frame_done(frame_done)
    );

    always @(posedge clk) begin
        if (frame_done) done_cnt++;
        if (conv_start) conv_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: pops one expected item per sample event
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 queue empty", 0, 1);
            end else begin
                exp_t e;
                string tag;
                e = exp_q.pop_front();
                tag = (e.idx <= 5) ? "R4" : ((e.idx <= 21) ? "R5" : "R6");
                check(dout_oe === e.oe, {tag, " oe"}, int'(dout_oe), int'(e.oe));
                if (e.oe) check(dout === e.d, {tag, " dout"}, int'(dout), int'(e.d));
            end
        end
    end

    function automatic exp_t expect_fall(input logic [W-1:0] word, input int i);
        exp_t e;
        e.idx = i;
        if (i < 5) begin
            e.oe = 1'b0; e.d = 1'b0;
        end else if (i == 5) begin
            e.oe = 1'b1; e.d = 1'b0;
        end else if (i <= 21) begin
            e.oe = 1'b1; e.d = word[21 - i];
        end else begin
            e.oe = 1'b1; e.d = 1'b0;
        end
        return e;
    endfunction

    // driver: abort_at = 0 runs the whole frame; swap_mid changes result_in after capture
    task automatic run_frame(input logic [W-1:0] word, input int nclk,
                             input int abort_at, input bit swap_mid, input string abort_req);
        int  d0, c0;
        bit  aborted;
        d0 = done_cnt;
        c0 = conv_cnt;
        aborted = 1'b0;
        result_in = word;
        @(negedge clk);
        csn_in = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 1; i <= nclk; i++) begin
            if (!aborted) begin
                sclk_in = 1'b1;
                repeat (HALF) @(negedge clk);
                if (i == abort_at) begin
                    sclk_in = 1'b0;
                    csn_in  = 1'b1;
                    aborted = 1'b1;
                    repeat (4) @(negedge clk);
                    check(dout_oe === 1'b0, abort_req, int'(dout_oe), 0);
                end else begin
                    sclk_in = 1'b0;
                    exp_q.push_back(expect_fall(word, i));
                    repeat (4) @(negedge clk);
                    -> sample_ev;
                    repeat (HALF - 4) @(negedge clk);
                    if (swap_mid && i == 6) result_in = ~word;
                end
            end
        end
        if (!aborted) begin
            csn_in = 1'b1;
            repeat (4) @(negedge clk);
            check(dout_oe === 1'b0, "R2 release", int'(dout_oe), 0);
            repeat (6) @(negedge clk);
            check(dout_oe === 1'b0, "R2 held", int'(dout_oe), 0);
            check(done_cnt - d0 == ((nclk >= 22) ? 1 : 0), "R7 done count",
                  done_cnt - d0, (nclk >= 22) ? 1 : 0);
        end else begin
            repeat (6) @(negedge clk);
            check(done_cnt == d0, {abort_req, " no done"}, done_cnt - d0, 0);
        end
        check(conv_cnt - c0 == 1, "R3 conv pulses", conv_cnt - c0, 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dout_oe === 1'b0, "R1 oe", int'(dout_oe), 0);
        check(dout === 1'b0, "R1 dout", int'(dout), 0);
        check(frame_done === 1'b0, "R1 done", int'(frame_done), 0);
        check(conv_start === 1'b0, "R1 conv", int'(conv_start), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        run_frame(16'hA5C3, 24, 0, 1'b0, "");     // R5 R6 typical frame
        run_frame(16'hFFFF, 22, 0, 1'b0, "");     // R6 minimum length
        run_frame(16'h0000, 30, 0, 1'b0, "");     // R6 long trailing zeros
        run_frame(16'h8001, 24, 0, 1'b0, "");     // R5 end bits
        run_frame(16'h3C5A, 24, 10, 1'b0, "R9 abort");
        run_frame(16'h1234, 24, 0, 1'b1, "");     // R11 input changes after capture
        run_frame(16'h6E91, 24, 22, 1'b0, "R10 coincident abort");
        run_frame(16'hC0DE, 24, 0, 1'b0, "");     // R9 counter restarted
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule